// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a synchronous memory device. It has four test pins: a test clock, a mode-select line, serial data in and serial data out with an output enable, plus an asynchronous power-on reset. A sixteen-state controller moves on each rising test-clock edge according to the mode-select level. An instruction register picks which data register sits between serial-in and serial-out. The data registers are a one-bit bypass stage, a 32-bit identification register and a boundary chain whose length is a parameter. The boundary chain captures a parallel sample of the device pins.

Every input is sampled on the rising edge of the test clock. Serial-out and its enable change only on the falling edge. Data enters at the most significant bit of the selected register and leaves from the least significant bit. After power-up the port sits in its reset state, so the device works normally with the test clock idle. Holding mode-select high (its pulled-up level) always returns the port to reset.

The instruction register is `IR_W` bits wide. Its codes are: all zeros = boundary drive (extest), value 1 = identification, value 2 = pin sample, all ones = bypass. Every other code behaves as bypass.

Top module: `bscan_port`

## Requirements
- R1: While `por_n` is low the controller is in Test-Logic-Reset, the current instruction is the identification code (value 1) and `tdo_oe` is 0. A data scan made straight after reset returns `IDCODE_VAL`.
- R2: The state advances at every rising `tck` edge according to `tms`, over the sixteen-state graph. With `tms`=1 in Test-Logic-Reset the controller stays there, and with `tms`=0 it moves to Run-Test/Idle. Five consecutive rising edges with `tms`=1 reach Test-Logic-Reset from any state.
- R3: `tdo` and `tdo_oe` change only on falling `tck` edges. `tdo_oe` is 1 only in the half-cycle after the controller entered Shift-IR or Shift-DR.
- R4: In Shift-IR and Shift-DR, each rising edge moves the selected register one place toward its LSB and loads `tdi` into its MSB. `tdo` presents the LSB from the falling edge that follows.
- R5: Capture-IR loads the instruction shift register with 1 in bit 0 and 0 in every other bit, so its two LSBs read 01.
- R6: The shifted instruction becomes current on the falling edge in Update-IR. In Test-Logic-Reset the current instruction returns to the identification code.
- R7: The identification code (value 1) selects the 32-bit identification register. It captures `IDCODE_VAL` in Capture-DR, and bit 0 of that value is 1.
- R8: The all-ones code, and any code that is not 0, 1, 2 or all ones, selects the bypass stage. The bypass stage captures 0 in Capture-DR and delays shifted data by exactly one clock.
- R9: Codes 0 (extest) and 2 (pin sample) select the `BSR_LEN`-bit boundary chain. The chain captures `pin_sample` in Capture-DR, with `pin_sample[0]` leaving first.
- R10: Exit1, Pause and Exit2 keep the shift register contents. A scan split by a pause continues where it stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; inputs sampled on rising edge, outputs driven on falling edge |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| tms | input | 1 | Mode select steering the controller |
| tdi | input | 1 | Serial data in, enters the MSB of the selected register |
| pin_sample | input | BSR_LEN | Parallel pin values captured by the boundary chain |
| tdo | output | 1 | Serial data out, LSB of the selected register |
| tdo_oe | output | 1 | Output enable for `tdo`; 0 models high impedance |

## Verification
A state change shows one rising edge after the `tms` level that causes it. The serial bit and enable for that state appear at the next falling edge. A captured value leaves `tdo` at the falling edge after the rising edge that leaves Capture, and a new instruction becomes current at the falling edge inside Update-IR. The bench drives `tms`, `tdi` and `pin_sample` 2 ns after each falling edge and compares the outputs at that same moment with a step-by-step model of the states and registers. It then checks 1 ns after the rising edge that `tdo` has not moved, so each result is judged only in the half-cycle where it is due. Directed scans of the identification, bypass, boundary and paused paths are mixed with a long random walk over `tms` and `tdi` from a fixed seed.

// File: rtl/bscan_pkg.sv
`timescale 1ns/1ps
package bscan_pkg;

   typedef enum logic [3:0] {
      ST_RESET, ST_IDLE,
      ST_DR_SEL, ST_DR_CAP, ST_DR_SHIFT, ST_DR_EXIT1, ST_DR_PAUSE, ST_DR_EXIT2, ST_DR_UPD,
      ST_IR_SEL, ST_IR_CAP, ST_IR_SHIFT, ST_IR_EXIT1, ST_IR_PAUSE, ST_IR_EXIT2, ST_IR_UPD
   } tap_state_t;

   typedef enum logic [1:0] {SEL_BYPASS, SEL_IDENT, SEL_CHAIN} dr_sel_t;

   function automatic tap_state_t next_state(input tap_state_t cur, input logic m);
      tap_state_t n;
      unique case (cur)
         ST_RESET:    n = m ? ST_RESET    : ST_IDLE;
         ST_IDLE:     n = m ? ST_DR_SEL   : ST_IDLE;
         ST_DR_SEL:   n = m ? ST_IR_SEL   : ST_DR_CAP;
         ST_DR_CAP:   n = m ? ST_DR_EXIT1 : ST_DR_SHIFT;
         ST_DR_SHIFT: n = m ? ST_DR_EXIT1 : ST_DR_SHIFT;
         ST_DR_EXIT1: n = m ? ST_DR_UPD   : ST_DR_PAUSE;
         ST_DR_PAUSE: n = m ? ST_DR_EXIT2 : ST_DR_PAUSE;
         ST_DR_EXIT2: n = m ? ST_DR_UPD   : ST_DR_SHIFT;
         ST_DR_UPD:   n = m ? ST_DR_SEL   : ST_IDLE;
         ST_IR_SEL:   n = m ? ST_RESET    : ST_IR_CAP;
         ST_IR_CAP:   n = m ? ST_IR_EXIT1 : ST_IR_SHIFT;
         ST_IR_SHIFT: n = m ? ST_IR_EXIT1 : ST_IR_SHIFT;
         ST_IR_EXIT1: n = m ? ST_IR_UPD   : ST_IR_PAUSE;
         ST_IR_PAUSE: n = m ? ST_IR_EXIT2 : ST_IR_PAUSE;
         ST_IR_EXIT2: n = m ? ST_IR_UPD   : ST_IR_SHIFT;
         ST_IR_UPD:   n = m ? ST_DR_SEL   : ST_IDLE;
         default:     n = ST_RESET;
      endcase
      return n;
   endfunction

endpackage

// File: rtl/tap_fsm.sv
`timescale 1ns/1ps
module tap_fsm
   import bscan_pkg::*;
(
   input  logic       tck,
   input  logic       por_n,
   input  logic       tms,
   output tap_state_t state
);

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n) state <= ST_RESET;
      else        state <= next_state(state, tms);
   end

   // checker: run length of consecutive tms=1 edges, saturating
   logic [2:0] ones_run;
   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)           ones_run <= '0;
      else if (!tms)        ones_run <= '0;
      else if (ones_run != 3'd7) ones_run <= ones_run + 3'd1;
   end

   p_tms_high_holds_r2: assert property (@(posedge tck) disable iff (!por_n)
      (state == ST_RESET && tms) |=> (state == ST_RESET));

   p_leave_reset_r2: assert property (@(posedge tck) disable iff (!por_n)
      (state == ST_RESET && !tms) |=> (state == ST_IDLE));

   p_five_ones_r2: assert property (@(posedge tck) disable iff (!por_n)
      (ones_run >= 3'd5) |-> (state == ST_RESET));

endmodule

// File: rtl/ir_unit.sv
`timescale 1ns/1ps
module ir_unit
   import bscan_pkg::*;
#(
   parameter int IR_W = 3,
   parameter logic [IR_W-1:0] OP_EXTEST = '0,
   parameter logic [IR_W-1:0] OP_IDCODE = IR_W'(1),
   parameter logic [IR_W-1:0] OP_SAMPLE = IR_W'(2),
   parameter logic [IR_W-1:0] OP_BYPASS = '1
)(
   input  logic       tck,
   input  logic       por_n,
   input  logic       tdi,
   input  tap_state_t state,
   output logic       ir_so,
   output dr_sel_t    dr_sel
);

   localparam logic [IR_W-1:0] CAP_PAT = {{(IR_W-1){1'b0}}, 1'b1};

   if (IR_W < 2) begin : g_bad_width
      $error("ir_unit: IR_W must be at least 2");
   end

   logic [IR_W-1:0] ir_sh;
   logic [IR_W-1:0] instr;

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                    ir_sh <= CAP_PAT;
      else if (state == ST_IR_CAP)   ir_sh <= CAP_PAT;
      else if (state == ST_IR_SHIFT) ir_sh <= {tdi, ir_sh[IR_W-1:1]};
   end

   always_ff @(negedge tck or negedge por_n) begin
      if (!por_n)                  instr <= OP_IDCODE;
      else if (state == ST_RESET)  instr <= OP_IDCODE;
      else if (state == ST_IR_UPD) instr <= ir_sh;
   end

   assign ir_so = ir_sh[0];

   always_comb begin
      if (instr == OP_IDCODE)                           dr_sel = SEL_IDENT;
      else if (instr == OP_EXTEST || instr == OP_SAMPLE) dr_sel = SEL_CHAIN;
      else                                              dr_sel = SEL_BYPASS;
   end

   p_ir_capture_r5: assert property (@(posedge tck) disable iff (!por_n)
      (state == ST_IR_CAP) |=> (ir_sh[1:0] == 2'b01));

   p_ident_in_reset_r6: assert property (@(posedge tck) disable iff (!por_n)
      (state == ST_RESET) |-> (instr == OP_IDCODE));

   p_update_loads_r6: assert property (@(posedge tck) disable iff (!por_n)
      (state == ST_IR_UPD) |-> (instr == ir_sh));

   p_ir_pause_holds_r10: assert property (@(posedge tck) disable iff (!por_n)
      (state == ST_IR_PAUSE) |=> $stable(ir_sh));

endmodule

// File: rtl/dr_chain.sv
`timescale 1ns/1ps
module dr_chain #(
   parameter int W = 32
)(
   input  logic         tck,
   input  logic         por_n,
   input  logic         tdi,
   input  logic         cap_en,
   input  logic         shift_en,
   input  logic [W-1:0] cap_val,
   output logic         so
);

   if (W < 1) begin : g_bad_len
      $error("dr_chain: W must be at least 1");
   end

   if (W == 1) begin : g_single
      always_ff @(posedge tck or negedge por_n) begin
         if (!por_n)        so <= 1'b0;
         else if (cap_en)   so <= cap_val[0];
         else if (shift_en) so <= tdi;
      end
   end else begin : g_multi
      logic [W-1:0] sr;
      always_ff @(posedge tck or negedge por_n) begin
         if (!por_n)        sr <= '0;
         else if (cap_en)   sr <= cap_val;
         else if (shift_en) sr <= {tdi, sr[W-1:1]};
      end
      assign so = sr[0];

      p_chain_hold_r10: assert property (@(posedge tck) disable iff (!por_n)
         (!cap_en && !shift_en) |=> $stable(sr));
   end

   p_capture_lsb_r9: assert property (@(posedge tck) disable iff (!por_n)
      cap_en |=> (so == $past(cap_val[0])));

endmodule

// File: rtl/bscan_port.sv
`timescale 1ns/1ps
module bscan_port
   import bscan_pkg::*;
#(
   parameter int          IR_W       = 3,
   parameter int          BSR_LEN    = 8,
   parameter logic [31:0] IDCODE_VAL = 32'h1A5C_3E0F
)(
   input  logic               tck,
   input  logic               por_n,
   input  logic               tms,
   input  logic               tdi,
   input  logic [BSR_LEN-1:0] pin_sample,
   output logic               tdo,
   output logic               tdo_oe
);

   localparam int ID_W = 32;

   if (IDCODE_VAL[0] != 1'b1) begin : g_bad_id
      $error("bscan_port: IDCODE_VAL bit 0 must be 1");
   end
   if (BSR_LEN < 1) begin : g_bad_bsr
      $error("bscan_port: BSR_LEN must be at least 1");
   end

   tap_state_t state;
   dr_sel_t    dr_sel;
   logic       ir_so, id_so, bsr_so, byp;
   logic       in_dr_cap, in_dr_shift, tdo_nxt, oe_nxt;

   tap_fsm u_fsm (
      .tck   (tck),
      .por_n (por_n),
      .tms   (tms),
      .state (state)
   );

   ir_unit #(.IR_W(IR_W)) u_ir (
      .tck    (tck),
      .por_n  (por_n),
      .tdi    (tdi),
      .state  (state),
      .ir_so  (ir_so),
      .dr_sel (dr_sel)
   );

   assign in_dr_cap   = (state == ST_DR_CAP);
   assign in_dr_shift = (state == ST_DR_SHIFT);

   dr_chain #(.W(ID_W)) u_ident (
      .tck      (tck),
      .por_n    (por_n),
      .tdi      (tdi),
      .cap_en   (in_dr_cap   && dr_sel == SEL_IDENT),
      .shift_en (in_dr_shift && dr_sel == SEL_IDENT),
      .cap_val  (IDCODE_VAL),
      .so       (id_so)
   );

   dr_chain #(.W(BSR_LEN)) u_chain (
      .tck      (tck),
      .por_n    (por_n),
      .tdi      (tdi),
      .cap_en   (in_dr_cap   && dr_sel == SEL_CHAIN),
      .shift_en (in_dr_shift && dr_sel == SEL_CHAIN),
      .cap_val  (pin_sample),
      .so       (bsr_so)
   );

   always_ff @(posedge tck or negedge por_n) begin
      if (!por_n)                                  byp <= 1'b0;
      else if (in_dr_cap && dr_sel == SEL_BYPASS)   byp <= 1'b0;
      else if (in_dr_shift && dr_sel == SEL_BYPASS) byp <= tdi;
   end

   always_comb begin
      oe_nxt = (state == ST_IR_SHIFT) || in_dr_shift;
      unique case (state)
         ST_IR_SHIFT: tdo_nxt = ir_so;
         ST_DR_SHIFT: begin
            unique case (dr_sel)
               SEL_IDENT: tdo_nxt = id_so;
               SEL_CHAIN: tdo_nxt = bsr_so;
               default:   tdo_nxt = byp;
            endcase
         end
         default:     tdo_nxt = 1'b0;
      endcase
   end

   always_ff @(negedge tck or negedge por_n) begin
      if (!por_n) begin
         tdo    <= 1'b0;
         tdo_oe <= 1'b0;
      end else begin
         tdo    <= tdo_nxt;
         tdo_oe <= oe_nxt;
      end
   end

   p_oe_shift_only_r3: assert property (@(posedge tck) disable iff (!por_n)
      tdo_oe |-> (state == ST_IR_SHIFT || state == ST_DR_SHIFT));

   p_bypass_delay_r8: assert property (@(posedge tck) disable iff (!por_n)
      (in_dr_shift && dr_sel == SEL_BYPASS) |=> (byp == $past(tdi)));

   p_bypass_capture_r8: assert property (@(posedge tck) disable iff (!por_n)
      (in_dr_cap && dr_sel == SEL_BYPASS) |=> (byp == 1'b0));

endmodule

// File: tb/bscan_port_test.sv
`timescale 1ns/1ps
module bscan_port_test;

   localparam int          IRW = 3;
   localparam int          BSR = 8;
   localparam logic [31:0] IDV = 32'h1A5C_3E0F;

   localparam int S_TLR = 0, S_RTI = 1, S_SDR = 2, S_CDR = 3, S_HDR = 4, S_E1D = 5,
                  S_PDR = 6, S_E2D = 7, S_UDR = 8, S_SIR = 9, S_CIR = 10, S_HIR = 11,
                  S_E1I = 12, S_PIR = 13, S_E2I = 14, S_UIR = 15;

   logic tck = 1'b0, por_n = 1'b0, tms = 1'b1, tdi = 1'b0;
   logic [BSR-1:0] pins = '0;
   logic tdo, tdo_oe;

   int checks = 0, errors = 0;
   bit done = 0;

   int             m_st;
   logic [IRW-1:0] m_ir, m_ins;
   logic           m_byp;
   logic [31:0]    m_id;
   logic [BSR-1:0] m_bsr;

   bscan_port #(.IR_W(IRW), .BSR_LEN(BSR), .IDCODE_VAL(IDV)) uut (
      .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi),
      .pin_sample(pins), .tdo(tdo), .tdo_oe(tdo_oe)
   );

   always #10 tck = ~tck;

   function automatic int nxt(input int s, input bit t);
      case (s)
         S_TLR: return t ? S_TLR : S_RTI;
         S_RTI: return t ? S_SDR : S_RTI;
         S_SDR: return t ? S_SIR : S_CDR;
         S_CDR: return t ? S_E1D : S_HDR;
         S_HDR: return t ? S_E1D : S_HDR;
         S_E1D: return t ? S_UDR : S_PDR;
         S_PDR: return t ? S_E2D : S_PDR;
         S_E2D: return t ? S_UDR : S_HDR;
         S_UDR: return t ? S_SDR : S_RTI;
         S_SIR: return t ? S_TLR : S_CIR;
         S_CIR: return t ? S_E1I : S_HIR;
         S_HIR: return t ? S_E1I : S_HIR;
         S_E1I: return t ? S_UIR : S_PIR;
         S_PIR: return t ? S_E2I : S_PIR;
         S_E2I: return t ? S_UIR : S_HIR;
         default: return t ? S_SDR : S_RTI;
      endcase
   endfunction

   // 0 bypass, 1 identification, 2 boundary chain
   function automatic int sel_of(input logic [IRW-1:0] c);
      if (c == IRW'(1)) return 1;
      if (c == '0 || c == IRW'(2)) return 2;
      return 0;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic step(input bit t, input bit d, output logic so);
      logic eo, eb;
      int   s;
      @(negedge tck); #2;
      if (m_st == S_UIR)      m_ins = m_ir;
      else if (m_st == S_TLR) m_ins = IRW'(1);
      s  = sel_of(m_ins);
      eo = (m_st == S_HIR || m_st == S_HDR);
      chk(tdo_oe === eo, "R3", "tdo_oe after falling edge", 64'(tdo_oe), 64'(eo));
      if (eo) begin
         if (m_st == S_HIR) eb = m_ir[0];
         else if (s == 1)   eb = m_id[0];
         else if (s == 2)   eb = m_bsr[0];
         else               eb = m_byp;
         chk(tdo === eb, "R4", "serial bit", 64'(tdo), 64'(eb));
      end
      so  = tdo;
      tms = t;
      tdi = d;
      case (m_st)
         S_CIR: m_ir = {{(IRW-1){1'b0}}, 1'b1};
         S_HIR: m_ir = {d, m_ir[IRW-1:1]};
         S_CDR: begin
            if (s == 1)      m_id  = IDV;
            else if (s == 2) m_bsr = pins;
            else             m_byp = 1'b0;
         end
         S_HDR: begin
            if (s == 1)      m_id  = {d, m_id[31:1]};
            else if (s == 2) m_bsr = {d, m_bsr[BSR-1:1]};
            else             m_byp = d;
         end
         default: ;
      endcase
      m_st = nxt(m_st, t);
      @(posedge tck); #1;
      chk(tdo === so, "R3", "tdo steady across rising edge", 64'(tdo), 64'(so));
   endtask

   // from Run-Test/Idle to Run-Test/Idle
   task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
      logic b;
      dout = '0;
      step(1, 0, b); step(0, 0, b); step(0, 0, b);
      for (int i = 0; i < n; i++) begin
         step(i == n - 1, din[i], b);
         dout[i] = b;
      end
      step(1, 0, b); step(0, 0, b);
   endtask

   task automatic load_ir(input logic [IRW-1:0] code, output logic [IRW-1:0] cap);
      logic b;
      step(1, 0, b); step(1, 0, b); step(0, 0, b); step(0, 0, b);
      for (int i = 0; i < IRW; i++) begin
         step(i == IRW - 1, code[i], b);
         cap[i] = b;
      end
      step(1, 0, b); step(0, 0, b);
   endtask

   initial begin
      repeat (200000) @(posedge tck);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [63:0]    got;
      logic [IRW-1:0] cap;
      logic           b;
      void'($urandom(32'd5150));
      m_st = S_TLR; m_ins = IRW'(1); m_ir = {{(IRW-1){1'b0}}, 1'b1};
      m_byp = 1'b0; m_id = '0; m_bsr = '0;

      #15;
      chk(tdo_oe === 1'b0, "R1", "tdo_oe in reset", 64'(tdo_oe), 64'(0));
      chk(tdo === 1'b0, "R1", "tdo in reset", 64'(tdo), 64'(0));
      @(negedge tck); #3; por_n = 1'b1;

      // R1 / R7: identification scan straight from reset
      step(0, 0, b);
      scan_dr(32, 64'h0, got);
      chk(got[31:0] === IDV, "R7", "identification after reset", got, 64'(IDV));

      // R5 / R8: bypass code
      load_ir('1, cap);
      chk(cap === {{(IRW-1){1'b0}}, 1'b1}, "R5", "Capture-IR pattern", 64'(cap), 64'(1));
      scan_dr(8, 64'hB5, got);
      chk(got[7:0] === 8'h6A, "R8", "bypass one-clock delay", got, 64'h6A);

      // R8: undefined code 3 falls back to bypass
      load_ir(IRW'(3), cap);
      scan_dr(8, 64'h3C, got);
      chk(got[7:0] === 8'h78, "R8", "undefined code uses bypass", got, 64'h78);

      // R9: pin sample (2) and extest (0) capture pin_sample
      pins = 8'hC3;
      load_ir(IRW'(2), cap);
      scan_dr(BSR, 64'h0, got);
      chk(got[BSR-1:0] === 8'hC3, "R9", "sample code captures pins", got, 64'hC3);
      pins = 8'h5A;
      load_ir('0, cap);
      scan_dr(BSR, 64'hFF, got);
      chk(got[BSR-1:0] === 8'h5A, "R9", "extest code captures pins", got, 64'h5A);

      // R2 / R6: five ones from inside Shift-IR, then hold high
      step(1, 0, b); step(1, 0, b); step(0, 0, b); step(0, 0, b);
      for (int i = 0; i < 5; i++) step(1, 0, b);
      chk(m_st == S_TLR, "R2", "bench walk reached reset", 64'(m_st), 64'(S_TLR));
      for (int i = 0; i < 12; i++) step(1, 0, b);
      step(0, 0, b);
      scan_dr(32, 64'h0, got);
      chk(got[31:0] === IDV, "R6", "reset restores identification code", got, 64'(IDV));
      chk(got[31:0] === IDV, "R2", "five tms=1 edges reach reset", got, 64'(IDV));

      // R10: identification scan split by Exit1/Pause/Exit2
      got = '0;
      step(1, 0, b); step(0, 0, b); step(0, 0, b);
      for (int i = 0; i < 10; i++) begin
         step(i == 9, 0, b);
         got[i] = b;
      end
      step(0, 0, b); step(0, 0, b); step(0, 0, b); step(1, 0, b); step(0, 0, b);
      for (int i = 10; i < 32; i++) begin
         step(i == 31, 0, b);
         got[i] = b;
      end
      step(1, 0, b); step(0, 0, b);
      chk(got[31:0] === IDV, "R10", "paused scan continues", got, 64'(IDV));

      // random walk checked against the bench model
      for (int i = 0; i < 6000; i++) begin
         if (i % 64 == 0) pins = BSR'($urandom);
         step(($urandom % 10) < 3, $urandom % 2, b);
      end

      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule